// File: doc/BRIEF.md
# Timer and Watchdog with One Shared Prescaler

This block pairs an 8-bit up-counting timer with a watchdog counter. A single 8-bit prescaler divides the clock events of whichever counter it is assigned to. The counter it is not assigned to advances once per event of its own. The timer counts either instruction-cycle enables or transitions on an external pin. The pin passes through a synchronizer and an edge detector before it reaches the prescaler, and the mode register chooses whether rising or falling transitions count. The watchdog counts enables from its own free-running oscillator, which is modelled here as a clock-enable input.

A processor core programs the block through an 8-bit mode register and can read or load the timer value. It restarts the watchdog with a clear strobe, or with the strobe it raises on entering sleep. Two outputs are one-cycle pulses. The first marks the timer wrapping from 0xFF to 0x00 and feeds the timer interrupt flag. The second marks a watchdog timeout and asks the system to restart execution at program address 0x000. After reset the prescaler serves the watchdog at its slowest setting.

Top module: `tkw_timer_wdog`

## Requirements
- R1: After synchronous reset the timer reads 0x00, both pulse outputs are low, and the mode register reads 0xFF. With that mode, the timer counts falling pin transitions one for one.
- R2: Mode bit 5 picks the timer event source: 0 counts cycles with `icyc_en` high, and 1 counts detected pin transitions while `icyc_en` is ignored.
- R3: Mode bit 4 picks the counted pin transition: 0 counts rising and 1 counts falling. A pin change driven before clock edge k shows up in the timer value after edge k+2.
- R4: With mode bit 3 at 0, the prescaler serves the timer. The timer then advances once per 2^(code+1) source events, where code is mode bits 2:0 (1:2 up to 1:256), and the watchdog advances on every oscillator enable.
- R5: With mode bit 3 at 1, the prescaler serves the watchdog. The watchdog then advances once per 2^code oscillator enables (1:1 up to 1:128), and the timer advances on every source event.
- R6: The timer wraps from 0xFF to 0x00, and `cnt_ovf` is high for exactly the one cycle in which the timer first reads 0x00.
- R7: A timer write loads `cnt_wdata` on the next edge and takes priority over an increment in that cycle. While the prescaler serves the timer, the write also restarts the prescaler count.
- R8: The watchdog wraps after 2^WD_W of its advances, and `wdog_rst_req` is high for one cycle at the wrap.
- R9: `wdog_clr` or `sleep_clr` zeroes the watchdog and wins over an advance in the same cycle, so no timeout is raised. While the prescaler serves the watchdog, either strobe also restarts the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| icyc_en | input | 1 | One-cycle enable per instruction cycle |
| wdog_osc_en | input | 1 | Enable from the watchdog oscillator |
| mode_we | input | 1 | Write strobe for the mode register |
| mode_wdata | input | 8 | Mode register write data |
| mode_rdata | output | 8 | Mode register contents |
| cnt_we | input | 1 | Timer write strobe |
| cnt_wdata | input | 8 | Timer write data |
| cnt_rdata | output | 8 | Timer value |
| wdog_clr | input | 1 | Clear-watchdog strobe |
| sleep_clr | input | 1 | Sleep-entry strobe, which also clears the watchdog |
| ext_pin | input | 1 | Asynchronous external count pin |
| cnt_ovf | output | 1 | Timer wrap pulse |
| wdog_rst_req | output | 1 | Watchdog timeout pulse |

## Verification
The same-cycle case that matters most is a watchdog clear that lands on the exact cycle in which the watchdog would wrap. The bench provokes it twice, once with `wdog_clr` and once with `sleep_clr`, by timing the strobe to the sixteenth oscillator enable of a 4-bit watchdog. It then expects `wdog_rst_req` to stay low and a timeout to follow a full period later. A second collision pairs a timer write with a running prescaler. There the loaded value must appear unchanged, and the next increment must come a full ratio after the write rather than at the point where the old count would have expired.

// File: rtl/tkw_pkg.sv
package tkw_pkg;

    localparam int PRE_W = 8;
    localparam int EXP_W = 4;
    localparam logic [7:0] MODE_RST = 8'hFF;

    typedef struct packed {
        logic [1:0] spare;
        logic       src_pin;
        logic       fall_edge;
        logic       to_wdog;
        logic [2:0] code;
    } mode_t;

    // Division exponent: the watchdog uses the code as is, the timer one more
    function automatic logic [EXP_W-1:0] div_exp(input mode_t m);
        logic [EXP_W-1:0] e;
        e = {1'b0, m.code};
        if (!m.to_wdog) e = e + 1'b1;
        return e;
    endfunction

    // Terminal prescaler count for a power-of-two ratio
    function automatic logic [PRE_W-1:0] div_limit(input logic [EXP_W-1:0] e);
        logic [PRE_W:0] t;
        t = (PRE_W+1)'(1) << e;
        t = t - (PRE_W+1)'(1);
        return t[PRE_W-1:0];
    endfunction

endpackage

// File: rtl/tkw_pin_edge.sv
module tkw_pin_edge #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic fall_sel,
    output logic evt
);
    logic [SYNC:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[SYNC-1:0], pin};
    end

    logic cur, prev;
    assign cur  = sh[SYNC-1];
    assign prev = sh[SYNC];
    assign evt  = fall_sel ? (prev & ~cur) : (cur & ~prev);
endmodule

// File: rtl/tkw_prescale.sv
module tkw_prescale
    import tkw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             evt,
    input  logic [PRE_W-1:0] limit,
    output logic             tick
);
    logic [PRE_W-1:0] cnt;

    // >= so that a ratio change mid-count still terminates promptly
    assign tick = evt && !clr && (cnt >= limit);

    always_ff @(posedge clk) begin
        if (rst || clr)  cnt <= '0;
        else if (evt)    cnt <= (cnt >= limit) ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/tkw_counter.sv
module tkw_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         inc,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)      q <= '0;
        else if (ld)  q <= ld_val;
        else if (inc) q <= q + 1'b1;
    end
endmodule

// File: rtl/tkw_timer_wdog.sv
module tkw_timer_wdog
    import tkw_pkg::*;
#(
    parameter int WD_W = 8,
    parameter int SYNC = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       icyc_en,
    input  logic       wdog_osc_en,
    input  logic       mode_we,
    input  logic [7:0] mode_wdata,
    output logic [7:0] mode_rdata,
    input  logic       cnt_we,
    input  logic [7:0] cnt_wdata,
    output logic [7:0] cnt_rdata,
    input  logic       wdog_clr,
    input  logic       sleep_clr,
    input  logic       ext_pin,
    output logic       cnt_ovf,
    output logic       wdog_rst_req
);
    mode_t mode_q;

    always_ff @(posedge clk) begin
        if (rst)          mode_q <= mode_t'(MODE_RST);
        else if (mode_we) mode_q <= mode_t'(mode_wdata);
    end
    assign mode_rdata = mode_q;

    logic pin_evt;
    tkw_pin_edge #(.SYNC(SYNC)) u_pin (
        .clk(clk), .rst(rst), .pin(ext_pin),
        .fall_sel(mode_q.fall_edge), .evt(pin_evt)
    );

    logic tm_evt, wd_clr, pre_evt, pre_clr, pre_tick, tm_inc, wd_inc;
    assign tm_evt  = mode_q.src_pin ? pin_evt : icyc_en;
    assign wd_clr  = wdog_clr | sleep_clr;
    assign pre_evt = mode_q.to_wdog ? wdog_osc_en : tm_evt;
    assign pre_clr = mode_q.to_wdog ? wd_clr : cnt_we;

    tkw_prescale u_pre (
        .clk(clk), .rst(rst), .clr(pre_clr), .evt(pre_evt),
        .limit(div_limit(div_exp(mode_q))), .tick(pre_tick)
    );

    assign tm_inc = mode_q.to_wdog ? tm_evt : pre_tick;
    assign wd_inc = mode_q.to_wdog ? pre_tick : wdog_osc_en;

    logic [7:0]      tm_q;
    logic [WD_W-1:0] wd_q;

    tkw_counter #(.W(8)) u_tmr (
        .clk(clk), .rst(rst), .ld(cnt_we), .ld_val(cnt_wdata),
        .inc(tm_inc), .q(tm_q)
    );
    tkw_counter #(.W(WD_W)) u_wdg (
        .clk(clk), .rst(rst), .ld(wd_clr), .ld_val('0),
        .inc(wd_inc), .q(wd_q)
    );
    assign cnt_rdata = tm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_ovf      <= 1'b0;
            wdog_rst_req <= 1'b0;
        end else begin
            cnt_ovf      <= tm_inc && !cnt_we && (&tm_q);
            wdog_rst_req <= wd_inc && !wd_clr && (&wd_q);
        end
    end
endmodule

// File: rtl/tkw_timer_wdog_chk.sv
module tkw_timer_wdog_chk (
    input logic       clk,
    input logic       rst,
    input logic       cnt_we,
    input logic [7:0] cnt_wdata,
    input logic [7:0] cnt_rdata,
    input logic       cnt_ovf,
    input logic       wdog_clr,
    input logic       sleep_clr,
    input logic       wdog_rst_req
);
    // R6
    ovf_zero_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_ovf |-> cnt_rdata == 8'h00);

    // R6
    ovf_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_ovf |=> !cnt_ovf);

    // R7
    load_val_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(cnt_we) && !$past(rst)) |-> cnt_rdata == $past(cnt_wdata));

    // R4
    step_one_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(cnt_we) && !$past(rst)) |->
        (cnt_rdata == $past(cnt_rdata) || cnt_rdata == $past(cnt_rdata) + 8'd1));

    // R9
    clr_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (($past(wdog_clr) || $past(sleep_clr)) && !$past(rst)) |-> !wdog_rst_req);

    // R8
    wdog_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        wdog_rst_req |=> !wdog_rst_req);
endmodule

bind tkw_timer_wdog tkw_timer_wdog_chk u_chk (
    .clk(clk), .rst(rst), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
    .cnt_rdata(cnt_rdata), .cnt_ovf(cnt_ovf), .wdog_clr(wdog_clr),
    .sleep_clr(sleep_clr), .wdog_rst_req(wdog_rst_req)
);

// File: tb/tkw_timer_wdog_test.sv
module tkw_timer_wdog_test;
    localparam int CLK_P = 10;
    localparam int SEL_CNT = 0, SEL_OVF = 1, SEL_WDG = 2, SEL_MODE = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       icyc_en = 1'b0, wdog_osc_en = 1'b0;
    logic       mode_we = 1'b0, cnt_we = 1'b0;
    logic [7:0] mode_wdata = '0, cnt_wdata = '0;
    logic       wdog_clr = 1'b0, sleep_clr = 1'b0, ext_pin = 1'b0;
    logic [7:0] mode_rdata, cnt_rdata;
    logic       cnt_ovf, wdog_rst_req;

    always #(CLK_P/2) clk = ~clk;

    tkw_timer_wdog #(.WD_W(4)) uut (
        .clk(clk), .rst(rst), .icyc_en(icyc_en), .wdog_osc_en(wdog_osc_en),
        .mode_we(mode_we), .mode_wdata(mode_wdata), .mode_rdata(mode_rdata),
        .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .cnt_rdata(cnt_rdata),
        .wdog_clr(wdog_clr), .sleep_clr(sleep_clr), .ext_pin(ext_pin),
        .cnt_ovf(cnt_ovf), .wdog_rst_req(wdog_rst_req)
    );

    typedef struct {
        int         cyc;
        int         sel;
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t sb[$];
    int cyc = 0;
    int checks = 0, fails = 0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Driver side: queue an expectation n edges ahead, kept in cycle order
    task automatic expect_at(input int n, input int sel, input logic [7:0] e, input string tag);
        item_t it;
        int pos;
        it.cyc = cyc + n; it.sel = sel; it.exp = e; it.tag = tag;
        pos = sb.size();
        for (int i = 0; i < sb.size(); i++) begin
            if (sb[i].cyc > it.cyc) begin pos = i; break; end
        end
        sb.insert(pos, it);
    endtask

    // Monitor: compare due items at the falling edge
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].cyc <= cyc) begin
            item_t it;
            logic [7:0] act;
            it = sb.pop_front();
            case (it.sel)
                SEL_CNT: act = cnt_rdata;
                SEL_OVF: act = {7'd0, cnt_ovf};
                SEL_WDG: act = {7'd0, wdog_rst_req};
                default: act = mode_rdata;
            endcase
            checks++;
            if (it.cyc != cyc || act !== it.exp) begin
                fails++;
                $display("FAIL %s at cycle %0d: actual %h expected %h", it.tag, cyc, act, it.exp);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_mode(input logic [7:0] v);
        mode_we = 1'b1; mode_wdata = v;
        expect_at(1, SEL_MODE, v, "mode write");
        step(1);
        mode_we = 1'b0;
    endtask

    task automatic wr_cnt(input logic [7:0] v);
        cnt_we = 1'b1; cnt_wdata = v;
        expect_at(1, SEL_CNT, v, "R7 timer load");
        step(1);
        cnt_we = 1'b0;
    endtask

    task automatic pulse_clr();
        wdog_clr = 1'b1; step(1); wdog_clr = 1'b0;
    endtask

    initial begin
        step(3);
        // R1 reset state
        expect_at(1, SEL_CNT, 8'h00, "R1 timer");
        expect_at(1, SEL_OVF, 8'h00, "R1 ovf");
        expect_at(1, SEL_WDG, 8'h00, "R1 wdog");
        expect_at(1, SEL_MODE, 8'hFF, "R1 mode");
        rst = 1'b0;
        step(3);

        // R1/R3 default mode: falling pin edges, 1:1
        ext_pin = 1'b1;
        expect_at(3, SEL_CNT, 8'h00, "R3 rising ignored");
        step(5);
        ext_pin = 1'b0;
        expect_at(2, SEL_CNT, 8'h00, "R3 latency");
        expect_at(3, SEL_CNT, 8'h01, "R1 R3 falling counted");
        step(5);

        // R4 1:2 on instruction cycles, R6 wrap
        wr_mode(8'h00);
        wr_cnt(8'hFD);
        icyc_en = 1'b1;
        expect_at(1, SEL_CNT, 8'hFD, "R4 1:2 hold");
        expect_at(2, SEL_CNT, 8'hFE, "R4 1:2 step");
        expect_at(4, SEL_CNT, 8'hFF, "R4 1:2 step");
        expect_at(5, SEL_OVF, 8'h00, "R6 no early ovf");
        expect_at(6, SEL_CNT, 8'h00, "R6 wrap");
        expect_at(6, SEL_OVF, 8'h01, "R6 ovf pulse");
        expect_at(7, SEL_OVF, 8'h00, "R6 ovf one cycle");
        step(8);
        icyc_en = 1'b0;
        step(2);

        // R4 1:256
        wr_mode(8'h07);
        wr_cnt(8'h10);
        icyc_en = 1'b1;
        expect_at(255, SEL_CNT, 8'h10, "R4 1:256 hold");
        expect_at(256, SEL_CNT, 8'h11, "R4 1:256 step");
        step(257);
        icyc_en = 1'b0;
        step(2);

        // R5 timer 1:1 when prescaler serves watchdog
        wr_mode(8'h08);
        wr_cnt(8'h50);
        icyc_en = 1'b1;
        expect_at(1, SEL_CNT, 8'h51, "R5 timer 1:1");
        expect_at(3, SEL_CNT, 8'h53, "R5 timer 1:1");
        step(3);
        icyc_en = 1'b0;
        step(2);

        // R7 write restarts the prescaler (1:4)
        wr_mode(8'h01);
        wr_cnt(8'h20);
        icyc_en = 1'b1;
        expect_at(3, SEL_CNT, 8'h20, "R4 1:4 hold");
        expect_at(4, SEL_CNT, 8'h21, "R4 1:4 step");
        step(6);
        cnt_we = 1'b1; cnt_wdata = 8'h40;
        expect_at(1, SEL_CNT, 8'h40, "R7 load over count");
        expect_at(4, SEL_CNT, 8'h40, "R7 prescaler restarted");
        expect_at(5, SEL_CNT, 8'h41, "R7 full ratio after write");
        step(1);
        cnt_we = 1'b0;
        step(5);
        icyc_en = 1'b0;
        step(2);

        // R8 / R9 watchdog 1:1, clears on the wrap cycle
        wr_mode(8'h00);
        pulse_clr();
        wdog_osc_en = 1'b1;
        expect_at(15, SEL_WDG, 8'h00, "R8 no early timeout");
        expect_at(16, SEL_WDG, 8'h01, "R8 timeout");
        expect_at(17, SEL_WDG, 8'h00, "R8 one cycle");
        step(31);
        wdog_clr = 1'b1;
        expect_at(1, SEL_WDG, 8'h00, "R9 clear wins");
        step(1);
        wdog_clr = 1'b0;
        step(15);
        sleep_clr = 1'b1;
        expect_at(1, SEL_WDG, 8'h00, "R9 sleep clear wins");
        step(1);
        sleep_clr = 1'b0;
        expect_at(16, SEL_WDG, 8'h01, "R9 full period after clear");
        step(17);
        wdog_osc_en = 1'b0;
        step(2);

        // R5 watchdog 1:2, R9 clear restarts prescaler
        wr_mode(8'h09);
        pulse_clr();
        wdog_osc_en = 1'b1;
        expect_at(31, SEL_WDG, 8'h00, "R5 wdog 1:2 hold");
        expect_at(32, SEL_WDG, 8'h01, "R5 wdog 1:2 timeout");
        step(32);
        wdog_osc_en = 1'b0;
        step(2);
        wdog_osc_en = 1'b1;
        step(1);
        wdog_osc_en = 1'b0;
        step(1);
        pulse_clr();
        wdog_osc_en = 1'b1;
        expect_at(31, SEL_WDG, 8'h00, "R9 prescaler cleared");
        expect_at(32, SEL_WDG, 8'h01, "R9 prescaler cleared");
        step(33);
        wdog_osc_en = 1'b0;
        step(2);

        // R2/R3 pin source, rising edges, 1:2; icyc_en ignored
        wr_mode(8'h20);
        wr_cnt(8'h70);
        icyc_en = 1'b1;
        ext_pin = 1'b1;
        expect_at(3, SEL_CNT, 8'h70, "R2 icyc ignored, first edge prescaled");
        step(5);
        ext_pin = 1'b0;
        step(5);
        ext_pin = 1'b1;
        expect_at(2, SEL_CNT, 8'h70, "R3 rising latency");
        expect_at(3, SEL_CNT, 8'h71, "R2 pin 1:2");
        step(5);
        ext_pin = 1'b0;
        expect_at(4, SEL_CNT, 8'h71, "R3 falling ignored");
        step(6);
        icyc_en = 1'b0;
        step(3);

        if (sb.size() != 0) begin
            fails += sb.size();
            $display("FAIL pending expectations: actual %0d expected 0", sb.size());
        end
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        end
        $finish;
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog expired: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule